// File: doc/BRIEF.md
# Phase-Matched Cache Refresh Scheduler

This block decides which lines of a small dynamic-memory cache need a refresh, and when. It divides the retention period into a power-of-two number of equal global phases. Each line keeps a stamp of the phase in which it was last touched. A line is refreshed only when the global phase comes round to the value of its stamp again. A line that was touched recently has in effect been refreshed by that access, so it is skipped until a full retention period has passed since then. Lines that hold no data are never refreshed: the block keeps its own copy of each line's valid state, so it never has to read the cache to find them.

When a phase boundary arrives, the scheduler stops accepting accesses. It then walks the line table once and sends one refresh request per cycle to the downstream refresh engine, which uses a valid/ready handshake. At the end of the walk it accepts accesses again. Data storage, tags and what the engine does with each request lie outside this block. Fill and invalidate strobes keep the valid copy in step with the cache, and the refresh engine uses the same invalidate strobe when it drops a line.

Top module: `phase_refresh_sched`

## Requirements
- R1: After reset the global phase is 0, every valid copy is clear, no refresh request is pending, the scan is idle and accesses are accepted (acc_ready_o = 1).
- R2: The global phase advances by one on each boundary and wraps from 2^PHASE_BITS-1 to 0. A boundary occurs after `interval_i` idle cycles, where a value of 0 counts as 1. The phase counter does not change at any other time.
- R3: An access accepted while the scan is idle sets that line's stamp to the current global phase. The line is then refreshed in the scan that begins when the global phase returns to that value.
- R4: While a scan is running, acc_ready_o is 0, and an offered access leaves every stamp unchanged.
- R5: A scan issues a refresh for a line only if its valid copy is set and its stamp equals the new global phase. Every line that meets both conditions is issued.
- R6: Refresh requests are issued in ascending line index, at most one per cycle. While ref_valid_o is high and ref_ready_i is low, ref_idx_o and ref_valid_o hold.
- R7: A scan starts in the cycle after the boundary. With ref_ready_i held high it lasts exactly NUM_LINES cycles. The interval divider is frozen while a scan runs.
- R8: A fill sets the line's valid copy and stamps the current phase. An invalidate clears the valid copy and wins over a fill to the same line in the same cycle. Both are accepted at any time, including during a scan.
- R9: With PHASE_BITS = 0 the global phase stays 0 and every valid line is refreshed at every boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| interval_i | input | DIV_W | Idle cycles per global phase |
| acc_valid_i | input | 1 | Read or write access to a line |
| acc_idx_i | input | IDX_W | Line index of the access |
| acc_ready_o | output | 1 | Access accepted (low during a scan) |
| fill_i | input | 1 | Line becomes valid |
| fill_idx_i | input | IDX_W | Line index of the fill |
| inval_i | input | 1 | Line becomes invalid |
| inval_idx_i | input | IDX_W | Line index of the invalidate |
| ref_valid_o | output | 1 | Refresh request valid |
| ref_idx_o | output | IDX_W | Line to refresh |
| ref_ready_i | input | 1 | Refresh engine takes the request |
| gphase_o | output | PH_W | Current global phase |
| scan_busy_o | output | 1 | Scan in progress |

## Verification
The main instance is built with 8 lines, 2 phase bits and an 8-bit divider programmed to 40 cycles. This gives a full retention period of four short phases, so the bench can run ten boundaries. That is enough to see the counter wrap, see a line come back to its stamp phase, and watch stale stamps survive a stalled access. A second instance uses 0 phase bits and shares the same fill and invalidate stimulus. It exercises the single-phase case, where every valid line is refreshed on each boundary.

// File: rtl/phase_refresh_pkg.sv
package phase_refresh_pkg;
  typedef enum logic {SCAN_IDLE, SCAN_RUN} scan_state_e;
endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int DIV_W      = 16,
  parameter int PH_W       = 2,
  parameter int NUM_PHASES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] interval_i,
  input  logic             hold_i,
  output logic             tick_o,
  output logic [PH_W-1:0]  gphase_o
);
  logic [DIV_W-1:0] cnt_q, limit;
  logic [PH_W-1:0]  gphase_q;

  assign limit    = (interval_i == '0) ? '0 : interval_i - 1'b1;
  assign tick_o   = !hold_i && (cnt_q == limit);
  assign gphase_o = gphase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      gphase_q <= '0;
    end else if (!hold_i) begin
      if (tick_o) begin
        cnt_q    <= '0;
        gphase_q <= (gphase_q == PH_W'(NUM_PHASES - 1)) ? '0 : gphase_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  gphase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(gphase_o));
endmodule

// File: rtl/phase_array.sv
module phase_array #(
  parameter int NUM_LINES = 16,
  parameter int PH_W      = 2,
  parameter int IDX_W     = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             acc_en_i,
  input  logic [IDX_W-1:0]                 acc_idx_i,
  input  logic                             fill_i,
  input  logic [IDX_W-1:0]                 fill_idx_i,
  input  logic                             inval_i,
  input  logic [IDX_W-1:0]                 inval_idx_i,
  input  logic [PH_W-1:0]                  gphase_i,
  output logic [NUM_LINES-1:0]             valid_o,
  output logic [NUM_LINES-1:0][PH_W-1:0]   lphase_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic stamp, set_v, clr_v;
    assign stamp = (acc_en_i && acc_idx_i == IDX_W'(i)) || (fill_i && fill_idx_i == IDX_W'(i));
    assign set_v = fill_i && fill_idx_i == IDX_W'(i);
    assign clr_v = inval_i && inval_idx_i == IDX_W'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i]  <= 1'b0;
        lphase_o[i] <= '0;
      end else begin
        if (stamp) lphase_o[i] <= gphase_i;
        if (clr_v) valid_o[i] <= 1'b0;
        else if (set_v) valid_o[i] <= 1'b1;
      end
    end
  end

  // R8
  inval_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !valid_o[$past(inval_idx_i)]);
  // R3
  stamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i |=> lphase_o[$past(acc_idx_i)] == $past(gphase_i));
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import phase_refresh_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int PH_W      = 2,
  parameter int IDX_W     = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           tick_i,
  input  logic [PH_W-1:0]                gphase_i,
  input  logic [NUM_LINES-1:0]           valid_i,
  input  logic [NUM_LINES-1:0][PH_W-1:0] lphase_i,
  input  logic                           ref_ready_i,
  output logic                           busy_o,
  output logic                           ref_valid_o,
  output logic [IDX_W-1:0]               ref_idx_o
);
  scan_state_e     state_q;
  logic [IDX_W-1:0] ptr_q;
  logic             hit, advance, last;

  assign busy_o      = (state_q == SCAN_RUN);
  assign hit         = valid_i[ptr_q] && (lphase_i[ptr_q] == gphase_i);
  assign ref_valid_o = busy_o && hit;
  assign ref_idx_o   = ptr_q;
  assign advance     = busy_o && (!hit || ref_ready_i);
  assign last        = (ptr_q == IDX_W'(NUM_LINES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SCAN_IDLE;
      ptr_q   <= '0;
    end else if (state_q == SCAN_IDLE) begin
      if (tick_i) begin
        state_q <= SCAN_RUN;
        ptr_q   <= '0;
      end
    end else if (advance) begin
      if (last) state_q <= SCAN_IDLE;
      else      ptr_q   <= ptr_q + 1'b1;
    end
  end

  // R6
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_o && !ref_ready_i |=> ref_valid_o && $stable(ref_idx_o));
  // R2
  tick_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> !busy_o);
endmodule

// File: rtl/phase_refresh_sched.sv
module phase_refresh_sched #(
  parameter int NUM_LINES  = 16,
  parameter int PHASE_BITS = 2,
  parameter int DIV_W      = 16,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int PH_W      = (PHASE_BITS > 0) ? PHASE_BITS : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] interval_i,
  input  logic             acc_valid_i,
  input  logic [IDX_W-1:0] acc_idx_i,
  output logic             acc_ready_o,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic             inval_i,
  input  logic [IDX_W-1:0] inval_idx_i,
  output logic             ref_valid_o,
  output logic [IDX_W-1:0] ref_idx_o,
  input  logic             ref_ready_i,
  output logic [PH_W-1:0]  gphase_o,
  output logic             scan_busy_o
);
  localparam int NUM_PHASES = 1 << PHASE_BITS;

  logic                           tick, busy, acc_en;
  logic [PH_W-1:0]                gphase;
  logic [NUM_LINES-1:0]           valid;
  logic [NUM_LINES-1:0][PH_W-1:0] lphase;

  assign acc_ready_o = !busy;
  assign acc_en      = acc_valid_i && !busy;
  assign gphase_o    = gphase;
  assign scan_busy_o = busy;

  phase_timer #(.DIV_W(DIV_W), .PH_W(PH_W), .NUM_PHASES(NUM_PHASES)) u_timer (
    .clk_i, .rst_ni, .interval_i, .hold_i(busy), .tick_o(tick), .gphase_o(gphase)
  );

  phase_array #(.NUM_LINES(NUM_LINES), .PH_W(PH_W), .IDX_W(IDX_W)) u_array (
    .clk_i, .rst_ni, .acc_en_i(acc_en), .acc_idx_i, .fill_i, .fill_idx_i,
    .inval_i, .inval_idx_i, .gphase_i(gphase), .valid_o(valid), .lphase_o(lphase)
  );

  scan_ctrl #(.NUM_LINES(NUM_LINES), .PH_W(PH_W), .IDX_W(IDX_W)) u_scan (
    .clk_i, .rst_ni, .tick_i(tick), .gphase_i(gphase), .valid_i(valid),
    .lphase_i(lphase), .ref_ready_i, .busy_o(busy), .ref_valid_o, .ref_idx_o
  );
endmodule

// File: tb/phase_refresh_sched_test.sv
`timescale 1ns/1ps
module phase_refresh_sched_test;
  localparam int NL = 8;
  localparam int PB = 2;
  localparam int NP = 1 << PB;
  localparam int L  = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic acc_valid = 0, fill = 0, inval = 0, ref_ready = 1;
  logic [2:0] acc_idx = 0, fill_idx = 0, inval_idx = 0;
  logic [7:0] interval = 8'(L);
  logic acc_ready, ref_valid, busy;
  logic [2:0] ref_idx;
  logic [1:0] gphase;
  logic s_acc_ready, s_ref_valid, s_busy;
  logic [2:0] s_ref_idx;
  logic [0:0] s_gphase;

  int n_chk = 0, n_fail = 0;
  int m_ph = 0;
  bit m_valid [NL];
  int m_lp [NL];

  phase_refresh_sched #(.NUM_LINES(NL), .PHASE_BITS(PB), .DIV_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .interval_i(interval), .acc_valid_i(acc_valid),
    .acc_idx_i(acc_idx), .acc_ready_o(acc_ready), .fill_i(fill), .fill_idx_i(fill_idx),
    .inval_i(inval), .inval_idx_i(inval_idx), .ref_valid_o(ref_valid), .ref_idx_o(ref_idx),
    .ref_ready_i(ref_ready), .gphase_o(gphase), .scan_busy_o(busy));

  phase_refresh_sched #(.NUM_LINES(NL), .PHASE_BITS(0), .DIV_W(8)) uut_single (
    .clk_i(clk), .rst_ni(rst_n), .interval_i(interval), .acc_valid_i(acc_valid),
    .acc_idx_i(acc_idx), .acc_ready_o(s_acc_ready), .fill_i(fill), .fill_idx_i(fill_idx),
    .inval_i(inval), .inval_idx_i(inval_idx), .ref_valid_o(s_ref_valid), .ref_idx_o(s_ref_idx),
    .ref_ready_i(1'b1), .gphase_o(s_gphase), .scan_busy_o(s_busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int valid_mask();
    int m = 0;
    for (int i = 0; i < NL; i++) if (m_valid[i]) m |= 1 << i;
    return m;
  endfunction

  function automatic int match_mask(input int ph);
    int m = 0;
    for (int i = 0; i < NL; i++) if (m_valid[i] && m_lp[i] == ph) m |= 1 << i;
    return m;
  endfunction

  // single-phase instance: every valid line per boundary (R9)
  bit s_busy_d = 0;
  int s_exp = 0, s_got = 0, s_last = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (s_busy && !s_busy_d) begin s_exp = valid_mask(); s_got = 0; s_last = -1; end
      if (s_busy && s_ref_valid) begin
        chk(int'(s_ref_idx) > s_last, "R9 ascending", int'(s_ref_idx), s_last + 1);
        s_last = int'(s_ref_idx);
        s_got |= 1 << s_ref_idx;
      end
      if (!s_busy && s_busy_d) chk(s_got == s_exp, "R9 refresh set", s_got, s_exp);
      s_busy_d = s_busy;
    end
  end

  task automatic t_reset();
    chk(gphase == 0, "R1 gphase", int'(gphase), 0);
    chk(!ref_valid, "R1 ref_valid", int'(ref_valid), 0);
    chk(acc_ready, "R1 acc_ready", int'(acc_ready), 1);
    chk(!busy, "R1 busy", int'(busy), 0);
    chk(s_gphase == 0, "R9 gphase", int'(s_gphase), 0);
  endtask

  task automatic do_fill(input int idx, input bit with_inval);
    fill = 1; fill_idx = 3'(idx);
    if (with_inval) begin inval = 1; inval_idx = 3'(idx); end
    @(negedge clk);
    fill = 0; inval = 0;
    if (with_inval) m_valid[idx] = 0;
    else begin m_valid[idx] = 1; m_lp[idx] = m_ph; end
  endtask

  task automatic do_access(input int idx);
    chk(acc_ready, "R3 accept idle", int'(acc_ready), 1);
    chk(int'(gphase) == m_ph, "R3 phase", int'(gphase), m_ph);
    acc_valid = 1; acc_idx = 3'(idx);
    @(negedge clk);
    acc_valid = 0;
    m_lp[idx] = m_ph;
  endtask

  task automatic run_scan(input string tag, input bit gap_chk, input bit stall,
                          input bit offer, input bit late_inval);
    int idle = 0, len = 0, got = 0, last = -1, held = -1, hold = 0, exp;
    while (!busy) begin idle++; @(negedge clk); end
    if (gap_chk) chk(idle == L, "R2 phase length", idle, L);
    m_ph = (m_ph + 1) % NP;
    exp = match_mask(m_ph);
    while (busy) begin
      len++;
      if (offer) begin
        acc_valid = 1; acc_idx = 3'd2;
        if (len == 1) chk(!acc_ready, "R4 stall ready", int'(acc_ready), 0);
      end
      if (late_inval && len == NL) begin
        inval = 1; inval_idx = 3'd6; m_valid[6] = 0;
      end
      if (stall && ref_valid && hold < 2) begin
        ref_ready = 0;
        if (hold > 0) chk(int'(ref_idx) == held, "R6 idx hold", int'(ref_idx), held);
        held = int'(ref_idx);
        hold++;
      end else begin
        ref_ready = 1;
        if (ref_valid) begin
          if (hold > 0) chk(int'(ref_idx) == held, "R6 idx hold", int'(ref_idx), held);
          hold = 0;
          chk(int'(ref_idx) > last, "R6 ascending", int'(ref_idx), last + 1);
          last = int'(ref_idx);
          got |= 1 << ref_idx;
        end
      end
      @(negedge clk);
      inval = 0;
    end
    acc_valid = 0; ref_ready = 1;
    chk(got == exp, {"R5 ", tag}, got, exp);
    if (!stall) chk(len == NL, "R7 scan length", len, NL);
    chk(int'(gphase) == m_ph, "R2 phase value", int'(gphase), m_ph);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin m_valid[i] = 0; m_lp[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    do_fill(2, 0);
    do_fill(6, 0);
    do_fill(4, 1);                       // R8 invalidate wins over fill
    run_scan("S1 none", 0, 0, 0, 0);
    run_scan("S2 gap", 1, 0, 0, 0);
    do_access(6);                        // R3 stamp phase 2
    do_fill(7, 0);                       // R8 fill stamps phase 2
    run_scan("R4 S3 offered access", 0, 0, 1, 0);
    run_scan("R2 S4 wrap", 0, 0, 0, 0);  // line 2 still phase 0
    run_scan("S5", 0, 0, 0, 0);
    run_scan("R3 S6 stall", 0, 1, 0, 0);
    run_scan("R8 S7 inval in scan", 0, 0, 0, 1);
    run_scan("S8", 0, 0, 0, 0);
    run_scan("S9", 0, 0, 0, 0);
    run_scan("R5 S10 invalid skipped", 0, 0, 0, 0);
    chk(s_gphase == 0, "R9 gphase end", int'(s_gphase), 0);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule